// File: doc/BRIEF.md
# Ethernet PHY Power-Down and Reset Sequencer

This block is the digital power-state and reset sequencer for two Ethernet PHY ports. For each port it holds a small set of host-written control bits. From them it decides whether the PHY is powered and when the PHY gets a reset pulse. Two power-down modes can apply. In the forced mode, a general power-down bit keeps the PHY off for as long as it is set. In the energy-gated mode, the PHY is off while the line shows no energy. The PHY always receives an automatic reset pulse when it leaves either mode. The PHY also receives one when the sequencer first powers it after the hardware reset ends.

Energy returning on a port in the energy-gated mode powers the PHY back up and sets a sticky wake flag. If that port is also enabled in the power-management control word, the flag drives a power-management event output. The host can also request a self-timed software reset per port. That reset lasts a fixed time and does not restore strap values. Strap values are copied into the power-down bits only on the hardware reset or on a strap-reload request.

The host writes one word per cycle through a select/port/data strobe. It reads any word back through a separate combinational read port. Word select codes: 0 basic control, 1 mode control/status, 2 interrupt flags, 3 power-management control (shared), 4 reset control (shared).

Top module: `phy_pm_ctrl`

## Requirements
- R1: The two ports are independent: a write, energy change or reset on one port never changes the power enable, reset pulse or wake flag of the other port.
- R2: Writing 1 to bit 11 of word 0 for a port drops that port's `phy_pwr_en` on the next cycle, and it stays low while the bit remains set, regardless of energy.
- R3: Every transition of `phy_pwr_en` from 0 to 1 starts an automatic reset. Such a transition happens when bit 11 is cleared, when the energy-gated mode is left, or on the first cycle after the hardware reset. `phy_rst` is high from the cycle `phy_pwr_en` rises, for exactly `AUTO_RST_CYCLES` cycles.
- R4: When bit 13 of word 1 is set and `energy_det` is low, the port is powered off. When bit 13 is low, energy has no effect on power.
- R5: Bit 1 of word 1 reads the port's `energy_det` value as registered one cycle earlier. The same registered value drives `energy_on`.
- R6: When `energy_det` rises on a port whose bit 13 is set and bit 11 is clear, power returns on the next cycle, an automatic reset starts, and the wake flag (bit 7 of word 2, output `wake_irq`) is set in that same cycle.
- R7: The wake flag stays set until the host writes word 2 for that port with bit 7 = 1. Writing 0 leaves it set.
- R8: `pme_out` is high exactly when some port has its wake flag set, its bit 13 set, and its enable set in word 3 (bit 14 for port 0, bit 15 for port 1).
- R9: Writing 1 to bit 1 (port 0) or bit 2 (port 1) of word 4 holds that port's `phy_rst` high for CLK_MHZ×102 cycles. The bit reads back 1 during the pulse and 0 after it. A new request during the pulse restarts the full count.
- R10: Entering a power-down mode and a software reset both leave bits 11 and 13 unchanged, and entering a power-down mode gives no reset pulse.
- R11: During the hardware reset (`rst_n` low) and on a `strap_reload` cycle, bits 11 and 13 load from `strap_gpd` and `strap_edpd`. During the hardware reset, power, reset pulse and wake flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_reload | input | 1 | One-cycle request to reload strap values |
| strap_gpd | input | 2 | Strap value of general power-down bit, per port |
| strap_edpd | input | 2 | Strap value of energy-gated enable bit, per port |
| energy_det | input | 2 | Synchronous line-energy indication, per port |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 3 | Word select for write |
| cfg_port | input | 1 | Port select for per-port words |
| cfg_wdata | input | 16 | Write data |
| rd_addr | input | 3 | Word select for read |
| rd_port | input | 1 | Port select for read |
| rd_data | output | 16 | Read data (combinational) |
| phy_pwr_en | output | 2 | PHY power enable, per port |
| phy_rst | output | 2 | PHY reset pulse, per port |
| energy_on | output | 2 | Registered energy status, per port |
| wake_irq | output | 2 | Sticky wake flag, per port |
| pme_out | output | 1 | Power-management event level |

## Verification
The bench sweeps every combination of forced power-down, energy-gated enable and line energy on each port. It also confirms that the other port does not move. A design that ignored one mode, or that decoded the port select wrongly, would show the wrong enable or disturb the neighbour. The bench times each reset pulse cycle by cycle, so an off-by-one timer or a missing reset on leaving a mode shows up as a wrong pulse length. A restart that failed to reload the timer would end the pulse early. The wake flag is probed with a zero write, with a clear aimed at the wrong port, and with the event enable off, so a non-sticky flag or an ungated event output fails. The bench also checks that a software reset keeps the host-written bits while a strap reload replaces them, which catches a design that reloads straps on the wrong event.

// File: rtl/phy_pm_pkg.sv
package phy_pm_pkg;
    localparam int NUM_PORTS = 2;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 3;
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    localparam logic [ADDR_W-1:0] SEL_BASIC  = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_IRQ    = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_PMCTL  = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_RSTCTL = 3'd4;

    localparam int B_FORCE_OFF = 11;
    localparam int B_ED_ENABLE = 13;
    localparam int B_ENERGY    = 1;
    localparam int B_WAKE      = 7;
    localparam int B_PM_BASE   = 14;
    localparam int B_SWRST_BASE = 1;
endpackage

// File: rtl/phy_rst_timer.sv
module phy_rst_timer #(
    parameter int unsigned AUTO_CYC = 16,
    parameter int unsigned SW_CYC   = 10200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_auto,
    input  logic load_sw,
    output logic busy,
    output logic sw_busy
);
    localparam int unsigned MAX_CYC = (SW_CYC > AUTO_CYC) ? SW_CYC : AUTO_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sw;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        // an automatic reset never shortens a longer pulse in flight
        if (load_auto && (tmr_q.cnt < CNT_W'(AUTO_CYC))) begin
            tmr_d.cnt = CNT_W'(AUTO_CYC);
        end
        if (tmr_d.cnt == '0) begin
            tmr_d.sw = 1'b0;
        end
        // a software request always restarts the full interval
        if (load_sw) begin
            tmr_d.cnt = CNT_W'(SW_CYC);
            tmr_d.sw  = 1'b1;
        end
        if (!rst_n) begin
            tmr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign busy    = (tmr_q.cnt != '0);
    assign sw_busy = tmr_q.sw;
endmodule

// File: rtl/phy_pm_port.sv
module phy_pm_port #(
    parameter int unsigned AUTO_CYC = 16,
    parameter int unsigned SW_CYC   = 10200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_reload,
    input  logic strap_gpd,
    input  logic strap_edpd,
    input  logic energy_det,
    input  logic wr_force,
    input  logic wr_force_val,
    input  logic wr_edmode,
    input  logic wr_edmode_val,
    input  logic wake_clr,
    input  logic swrst_req,
    output logic force_off,
    output logic ed_enable,
    output logic energy_on,
    output logic pwr_en,
    output logic phy_rst,
    output logic wake_flag,
    output logic sw_busy
);
    typedef struct packed {
        logic force_off;
        logic ed_enable;
        logic energy;
        logic pwr;
        logic wake;
    } port_t;

    port_t st_d, st_q;
    logic  power_up_d;
    logic  energy_wake_d;

    always_comb begin
        st_d        = st_q;
        st_d.energy = energy_det;
        if (wr_force) begin
            st_d.force_off = wr_force_val;
        end
        if (wr_edmode) begin
            st_d.ed_enable = wr_edmode_val;
        end
        if (strap_reload) begin
            st_d.force_off = strap_gpd;
            st_d.ed_enable = strap_edpd;
        end
        st_d.pwr = !st_d.force_off && !(st_d.ed_enable && !st_d.energy);

        power_up_d    = st_d.pwr && !st_q.pwr;
        energy_wake_d = power_up_d && st_d.ed_enable && st_d.energy && !st_q.energy;

        if (wake_clr) begin
            st_d.wake = 1'b0;
        end
        if (energy_wake_d) begin
            st_d.wake = 1'b1;
        end

        if (!rst_n) begin
            st_d.force_off = strap_gpd;
            st_d.ed_enable = strap_edpd;
            st_d.energy    = 1'b0;
            st_d.pwr       = 1'b0;
            st_d.wake      = 1'b0;
            power_up_d     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    phy_rst_timer #(
        .AUTO_CYC (AUTO_CYC),
        .SW_CYC   (SW_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_auto (power_up_d),
        .load_sw   (swrst_req && rst_n),
        .busy      (phy_rst),
        .sw_busy   (sw_busy)
    );

    assign force_off = st_q.force_off;
    assign ed_enable = st_q.ed_enable;
    assign energy_on = st_q.energy;
    assign pwr_en    = st_q.pwr;
    assign wake_flag = st_q.wake;
endmodule

// File: rtl/phy_pm_status.sv
module phy_pm_status
    import phy_pm_pkg::*;
(
    input  logic [NUM_PORTS-1:0] force_off,
    input  logic [NUM_PORTS-1:0] ed_enable,
    input  logic [NUM_PORTS-1:0] energy_on,
    input  logic [NUM_PORTS-1:0] wake_flag,
    input  logic [NUM_PORTS-1:0] sw_busy,
    input  logic [NUM_PORTS-1:0] pm_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [PORT_W-1:0]    rd_port,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 pme_out
);
    logic [NUM_PORTS-1:0] pme_term;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pme
        assign pme_term[p] = wake_flag[p] && ed_enable[p] && pm_en[p];
    end

    assign pme_out = |pme_term;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            SEL_BASIC: rd_data[B_FORCE_OFF] = force_off[rd_port];
            SEL_MODE: begin
                rd_data[B_ED_ENABLE] = ed_enable[rd_port];
                rd_data[B_ENERGY]    = energy_on[rd_port];
            end
            SEL_IRQ:   rd_data[B_WAKE] = wake_flag[rd_port];
            SEL_PMCTL: rd_data[B_PM_BASE +: NUM_PORTS] = pm_en;
            SEL_RSTCTL: rd_data[B_SWRST_BASE +: NUM_PORTS] = sw_busy;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/phy_pm_ctrl.sv
module phy_pm_ctrl
    import phy_pm_pkg::*;
#(
    parameter int unsigned CLK_MHZ         = 100,
    parameter int unsigned AUTO_RST_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_reload,
    input  logic [1:0]           strap_gpd,
    input  logic [1:0]           strap_edpd,
    input  logic [1:0]           energy_det,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic                 cfg_port,
    input  logic [15:0]          cfg_wdata,
    input  logic [2:0]           rd_addr,
    input  logic                 rd_port,
    output logic [15:0]          rd_data,
    output logic [1:0]           phy_pwr_en,
    output logic [1:0]           phy_rst,
    output logic [1:0]           energy_on,
    output logic [1:0]           wake_irq,
    output logic                 pme_out
);
    localparam int unsigned SW_RST_CYCLES = CLK_MHZ * 102;

    typedef struct packed {
        logic [NUM_PORTS-1:0] pm_en;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_PORTS-1:0] wr_force, wr_edmode, wake_clr, swrst_req;
    logic [NUM_PORTS-1:0] force_off, ed_enable, sw_busy;

    always_comb begin
        top_d = top_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            wr_force[p]  = cfg_we && (cfg_addr == SEL_BASIC) && (cfg_port == PORT_W'(p));
            wr_edmode[p] = cfg_we && (cfg_addr == SEL_MODE)  && (cfg_port == PORT_W'(p));
            wake_clr[p]  = cfg_we && (cfg_addr == SEL_IRQ)   && (cfg_port == PORT_W'(p))
                           && cfg_wdata[B_WAKE];
            swrst_req[p] = cfg_we && (cfg_addr == SEL_RSTCTL) && cfg_wdata[B_SWRST_BASE + p];
        end
        if (cfg_we && (cfg_addr == SEL_PMCTL)) begin
            top_d.pm_en = cfg_wdata[B_PM_BASE +: NUM_PORTS];
        end
        if (!rst_n) begin
            top_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        phy_pm_port #(
            .AUTO_CYC (AUTO_RST_CYCLES),
            .SW_CYC   (SW_RST_CYCLES)
        ) u_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .strap_reload  (strap_reload),
            .strap_gpd     (strap_gpd[p]),
            .strap_edpd    (strap_edpd[p]),
            .energy_det    (energy_det[p]),
            .wr_force      (wr_force[p]),
            .wr_force_val  (cfg_wdata[B_FORCE_OFF]),
            .wr_edmode     (wr_edmode[p]),
            .wr_edmode_val (cfg_wdata[B_ED_ENABLE]),
            .wake_clr      (wake_clr[p]),
            .swrst_req     (swrst_req[p]),
            .force_off     (force_off[p]),
            .ed_enable     (ed_enable[p]),
            .energy_on     (energy_on[p]),
            .pwr_en        (phy_pwr_en[p]),
            .phy_rst       (phy_rst[p]),
            .wake_flag     (wake_irq[p]),
            .sw_busy       (sw_busy[p])
        );
    end

    phy_pm_status u_status (
        .force_off (force_off),
        .ed_enable (ed_enable),
        .energy_on (energy_on),
        .wake_flag (wake_irq),
        .sw_busy   (sw_busy),
        .pm_en     (top_q.pm_en),
        .rd_addr   (rd_addr),
        .rd_port   (rd_port),
        .rd_data   (rd_data),
        .pme_out   (pme_out)
    );
endmodule

// File: rtl/phy_pm_ctrl_chk.sv
module phy_pm_ctrl_chk
    import phy_pm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        strap_reload,
    input logic        cfg_we,
    input logic [2:0]  cfg_addr,
    input logic        cfg_port,
    input logic [15:0] cfg_wdata,
    input logic [1:0]  phy_pwr_en,
    input logic [1:0]  phy_rst,
    input logic [1:0]  wake_irq,
    input logic        pme_out
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        p_force_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == SEL_BASIC && cfg_port == PORT_W'(p)
             && cfg_wdata[B_FORCE_OFF] && !strap_reload) |=> !phy_pwr_en[p]);

        p_powerup_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(phy_pwr_en[p]) |-> phy_rst[p]);

        p_wake_with_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_irq[p]) |-> $rose(phy_pwr_en[p]));

        p_wake_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_irq[p] && !(cfg_we && cfg_addr == SEL_IRQ && cfg_port == PORT_W'(p)
              && cfg_wdata[B_WAKE])) |=> wake_irq[p]);

        p_swrst_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == SEL_RSTCTL && cfg_wdata[B_SWRST_BASE + p]) |=> phy_rst[p]);
    end

    p_pme_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_out |-> (wake_irq != '0));
endmodule

bind phy_pm_ctrl phy_pm_ctrl_chk u_chk (.*);

// File: tb/phy_pm_ctrl_test.sv
module phy_pm_ctrl_test;
    localparam int CLK_MHZ = 1;
    localparam int AUTO    = 4;
    localparam int SWC     = CLK_MHZ * 102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_reload = 1'b0;
    logic [1:0]  strap_gpd = 2'b01;
    logic [1:0]  strap_edpd = 2'b00;
    logic [1:0]  energy_det = 2'b00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic        cfg_port = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic        rd_port = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  phy_pwr_en, phy_rst, energy_on, wake_irq;
    logic        pme_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    phy_pm_ctrl #(.CLK_MHZ(CLK_MHZ), .AUTO_RST_CYCLES(AUTO)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic p, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_port = p; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic p, output logic [15:0] d);
        rd_addr = a; rd_port = p;
        #1 d = rd_data;
    endtask

    task automatic pulse_len(input int p, output int n);
        n = 0;
        while (phy_rst[p] === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        logic other;

        repeat (3) @(negedge clk);
        chk("R11 reset pwr", phy_pwr_en, 2'b00);
        chk("R11 reset rst", phy_rst, 2'b00);
        chk("R11 reset wake", {pme_out, wake_irq}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 strap power", phy_pwr_en, 2'b10);
        chk("R3 power-on reset", phy_rst, 2'b10);
        pulse_len(1, n);
        chk("R3 power-on reset length", n, AUTO);
        rd(3'd0, 1'b0, v);
        chk("R11 strap bit11", v, 16'h0800);

        // leave forced power-down on port 0
        wr(3'd0, 1'b0, 16'h0000);
        chk("R3 power up", phy_pwr_en[0], 1'b1);
        chk("R1 neighbour rst", phy_rst[1], 1'b0);
        pulse_len(0, n);
        chk("R3 auto reset length", n, AUTO);

        // enter forced power-down
        wr(3'd0, 1'b0, 16'h0800);
        chk("R2 power off", phy_pwr_en[0], 1'b0);
        chk("R10 no reset on entry", phy_rst[0], 1'b0);
        energy_det[0] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 stays off", phy_pwr_en[0], 1'b0);
        energy_det[0] = 1'b0;

        // energy-gated mode on port 1, no energy
        wr(3'd1, 1'b1, 16'h2000);
        chk("R4 gated off", phy_pwr_en[1], 1'b0);
        chk("R10 no reset on gated entry", phy_rst[1], 1'b0);
        rd(3'd1, 1'b1, v);
        chk("R5 energy bit low", v, 16'h2000);
        wr(3'd3, 1'b0, 16'h8000);
        chk("R8 no flag no event", pme_out, 1'b0);

        // energy returns
        @(negedge clk);
        energy_det[1] = 1'b1;
        @(negedge clk);
        chk("R6 power back", phy_pwr_en[1], 1'b1);
        chk("R6 wake flag", wake_irq[1], 1'b1);
        chk("R8 event", pme_out, 1'b1);
        chk("R5 energy_on", energy_on[1], 1'b1);
        pulse_len(1, n);
        chk("R6 wake reset length", n, AUTO);
        rd(3'd1, 1'b1, v);
        chk("R5 energy bit high", v, 16'h2002);
        rd(3'd2, 1'b1, v);
        chk("R6 flag bit7", v, 16'h0080);

        // sticky flag
        wr(3'd2, 1'b1, 16'h0000);
        chk("R7 zero write keeps", wake_irq[1], 1'b1);
        wr(3'd2, 1'b0, 16'h0080);
        chk("R1 other port clear", wake_irq[1], 1'b1);
        wr(3'd2, 1'b1, 16'h0080);
        chk("R7 clear", wake_irq[1], 1'b0);
        chk("R8 event clears", pme_out, 1'b0);

        // event gating by enable word
        @(negedge clk);
        energy_det[1] = 1'b0;
        @(negedge clk);
        chk("R4 energy lost", phy_pwr_en[1], 1'b0);
        wr(3'd3, 1'b0, 16'h4000);
        energy_det[1] = 1'b1;
        @(negedge clk);
        chk("R6 wake with event off", wake_irq[1], 1'b1);
        chk("R8 event masked", pme_out, 1'b0);
        wr(3'd3, 1'b0, 16'hC000);
        chk("R8 event unmasked", pme_out, 1'b1);
        wr(3'd1, 1'b1, 16'h0000);
        chk("R8 event needs bit13", pme_out, 1'b0);
        wr(3'd2, 1'b1, 16'h0080);

        // leaving energy-gated mode without energy
        wr(3'd1, 1'b1, 16'h2000);
        energy_det[1] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 gated off again", phy_pwr_en[1], 1'b0);
        wr(3'd1, 1'b1, 16'h0000);
        chk("R4 disabled mode powers", phy_pwr_en[1], 1'b1);
        chk("R3 reset on mode exit", phy_rst[1], 1'b1);
        chk("R6 no wake on mode exit", wake_irq[1], 1'b0);

        // sweep forced / gated / energy on each port
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic g, e, en, exp;
                g = c[0]; e = c[1]; en = c[2];
                other = phy_pwr_en[1-p];
                energy_det[p] = en;
                wr(3'd0, p[0], {4'b0, g, 11'b0});
                wr(3'd1, p[0], {2'b0, e, 13'b0});
                @(negedge clk);
                exp = !g && !(e && !en);
                chk($sformatf("R4 R2 sweep p%0d c%0d", p, c), phy_pwr_en[p], exp);
                chk($sformatf("R1 sweep other p%0d c%0d", p, c), phy_pwr_en[1-p], other);
            end
        end
        wr(3'd2, 1'b0, 16'h0080);
        wr(3'd2, 1'b1, 16'h0080);

        // software reset on port 1 with host bits differing from straps
        energy_det[1] = 1'b1;
        wr(3'd0, 1'b1, 16'h0000);
        wr(3'd1, 1'b1, 16'h2000);
        repeat (10) @(negedge clk);
        wr(3'd4, 1'b0, 16'h0004);
        chk("R9 swrst starts", phy_rst, 2'b10);
        rd(3'd4, 1'b0, v);
        chk("R9 busy bit", v, 16'h0004);
        repeat (50) @(negedge clk);
        wr(3'd4, 1'b0, 16'h0004);
        chk("R1 port0 untouched", phy_rst[0], 1'b0);
        pulse_len(1, n);
        chk("R9 restarted length", n, SWC);
        rd(3'd4, 1'b0, v);
        chk("R9 self clear", v, 16'h0000);
        rd(3'd1, 1'b1, v);
        chk("R10 swrst keeps bit13", v, 16'h2002);
        chk("R10 power kept", phy_pwr_en[1], 1'b1);

        // strap reload
        wr(3'd0, 1'b0, 16'h0000);
        @(negedge clk);
        strap_reload = 1'b1;
        @(negedge clk);
        strap_reload = 1'b0;
        rd(3'd1, 1'b1, v);
        chk("R11 reload bit13", v, 16'h0002);
        rd(3'd0, 1'b0, v);
        chk("R11 reload bit11", v, 16'h0800);
        chk("R11 reload power", phy_pwr_en, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule